// File: doc/BRIEF.md
# Integer Exception Flag Unit

This unit keeps the integer exception word of a 32-bit execution core. The word holds three flag bits and a 7-bit byte count. The flags are a sticky summary overflow, an overflow and a carry; the byte count is used by string loads and stores. Each cycle, the arithmetic pipe reports the class of the operation that is completing, along with its raw evidence. That evidence is the carries out of the two most significant bit positions, whether a multiply or divide result fits in 32 bits, and whether a right algebraic shift of a negative operand lost any one bits. The unit derives the new flags from this report. The adder, multiplier, divider and shifter themselves are outside the block.

Two other paths change the word. Software can load the word with a full write. A move into a condition field takes the three flag bits, padded with a zero, and clears them in the same cycle. The current summary-overflow value, including any overflow raised by the operation completing this cycle, is also exported combinationally. The condition register unit uses it to fill the fourth bit of a record-form result.

Top module: `xef_unit`

## Requirements
- R1: After reset, `xer_q` is all zeros.
- R2: An operation of class ADD (`op_class`=2) with `ovf_en`=1 sets overflow (bit 30) to `carry32 ^ carry33` and leaves carry (bit 29) unchanged.
- R3: An operation of class ADDC (`op_class`=3) sets carry to `carry32`, whatever the value of `ovf_en`. With `ovf_en`=1 it also sets overflow to `carry32 ^ carry33`.
- R4: An operation of class MULDIV (`op_class`=4) with `ovf_en`=1 sets overflow to `!md_fits`.
- R5: An operation of class SRAW (`op_class`=5) sets carry to `sra_lost` and leaves overflow and summary overflow unchanged.
- R6: Classes NONE (0) and CMP (1), and classes ADD or MULDIV with `ovf_en`=0, leave the whole word unchanged.
- R7: Summary overflow (bit 31) is set whenever an operation sets overflow. No operation ever clears it, including one that clears overflow.
- R8: A write (`wr_en`) loads summary overflow, overflow, carry and byte count from `wr_data` bits 31, 30, 29 and 6:0. Bits 28:7 of `xer_q` always read zero. Writing summary overflow 0 with overflow 1 leaves exactly that state.
- R9: While `copy_req` is high, `copy_nib` equals {summary overflow, overflow, carry, 0} of the current word. At the following edge those three bits clear and the byte count is kept.
- R10: A write takes priority over a copy, and a copy takes priority over a reported operation. The lower-priority request in the same cycle has no effect.
- R11: `so_now` equals the stored summary overflow OR'ed with any overflow being set by a valid operation in the same cycle, before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_class | input | 3 | Operation class: 0 NONE, 1 CMP, 2 ADD, 3 ADDC, 4 MULDIV, 5 SRAW |
| ovf_en | input | 1 | Operation requests overflow recording |
| carry32 | input | 1 | Carry out of the most significant result bit |
| carry33 | input | 1 | Carry out of the next bit down |
| md_fits | input | 1 | Multiply/divide result fits in 32 bits |
| sra_lost | input | 1 | Algebraic shift of a negative operand lost one bits |
| wr_en | input | 1 | Explicit write of the whole word |
| wr_data | input | 32 | Write data |
| copy_req | input | 1 | Copy flags into a condition field and clear them |
| xer_q | output | 32 | Current word |
| so_now | output | 1 | Summary overflow including this cycle's operation |
| copy_nib | output | 4 | Flag nibble for the condition field |

## Verification
The bench first writes summary overflow 0 with overflow 1. A design that ties summary overflow to overflow on writes would show bit 31 set. An add that clears overflow follows a set summary overflow, and a non-sticky design would drop bit 31 there. The copy is checked for both the nibble value and the clear, and a design that clears the byte count or misses the clear shows up at the next edge. Same-cycle write/copy/operation collisions expose a wrong priority order. A multiply overflow from a clear state catches a `so_now` that only reports the registered bit.

// File: rtl/xef_pkg.sv
package xef_pkg;

    typedef enum logic [2:0] {
        XOP_NONE   = 3'd0,
        XOP_CMP    = 3'd1,
        XOP_ADD    = 3'd2,
        XOP_ADDC   = 3'd3,
        XOP_MULDIV = 3'd4,
        XOP_SRAW   = 3'd5
    } xef_op_e;

    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } xef_flags_t;

endpackage

// File: rtl/xef_ovf_eval.sv
module xef_ovf_eval
    import xef_pkg::*;
(
    input  logic    op_valid,
    input  xef_op_e op_class,
    input  logic    ovf_en,
    input  logic    carry32,
    input  logic    carry33,
    input  logic    md_fits,
    output logic    ov_touch,
    output logic    ov_val
);
    always_comb begin
        ov_touch = 1'b0;
        ov_val   = 1'b0;
        if (op_valid && ovf_en) begin
            case (op_class)
                XOP_ADD, XOP_ADDC: begin
                    ov_touch = 1'b1;
                    ov_val   = carry32 ^ carry33;
                end
                XOP_MULDIV: begin
                    ov_touch = 1'b1;
                    ov_val   = ~md_fits;
                end
                default: begin
                    ov_touch = 1'b0;
                    ov_val   = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/xef_ca_eval.sv
module xef_ca_eval
    import xef_pkg::*;
(
    input  logic    op_valid,
    input  xef_op_e op_class,
    input  logic    carry32,
    input  logic    sra_lost,
    output logic    ca_touch,
    output logic    ca_val
);
    always_comb begin
        ca_touch = 1'b0;
        ca_val   = 1'b0;
        if (op_valid) begin
            case (op_class)
                XOP_ADDC: begin
                    ca_touch = 1'b1;
                    ca_val   = carry32;
                end
                XOP_SRAW: begin
                    ca_touch = 1'b1;
                    ca_val   = sra_lost;
                end
                default: begin
                    ca_touch = 1'b0;
                    ca_val   = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/xef_next.sv
module xef_next
    import xef_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  xef_flags_t       cur_flags,
    input  logic [CNT_W-1:0] cur_cnt,
    input  logic             wr_en,
    input  xef_flags_t       wr_flags,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             copy_req,
    input  logic             ov_touch,
    input  logic             ov_val,
    input  logic             ca_touch,
    input  logic             ca_val,
    output xef_flags_t       nxt_flags,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             so_final
);
    assign so_final = cur_flags.so | (ov_touch & ov_val);

    always_comb begin
        nxt_flags = cur_flags;
        nxt_cnt   = cur_cnt;
        if (wr_en) begin
            nxt_flags = wr_flags;
            nxt_cnt   = wr_cnt;
        end else if (copy_req) begin
            nxt_flags = '0;
        end else begin
            if (ov_touch) begin
                nxt_flags.ov = ov_val;
                nxt_flags.so = so_final;
            end
            if (ca_touch) begin
                nxt_flags.ca = ca_val;
            end
        end
    end
endmodule

// File: rtl/xef_unit.sv
module xef_unit
    import xef_pkg::*;
#(
    parameter int XW    = 32,
    parameter int CNT_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_class,
    input  logic          ovf_en,
    input  logic          carry32,
    input  logic          carry33,
    input  logic          md_fits,
    input  logic          sra_lost,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_data,
    input  logic          copy_req,
    output logic [XW-1:0] xer_q,
    output logic          so_now,
    output logic [3:0]    copy_nib
);
    localparam int SO_BIT = XW - 1;
    localparam int OV_BIT = XW - 2;
    localparam int CA_BIT = XW - 3;

    xef_op_e          cls;
    xef_flags_t       flags_q, flags_d, wr_flags;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ov_touch, ov_val, ca_touch, ca_val;
    logic             wr_unused;

    assign cls       = xef_op_e'(op_class);
    assign wr_flags  = '{so: wr_data[SO_BIT], ov: wr_data[OV_BIT], ca: wr_data[CA_BIT]};
    assign wr_unused = ^wr_data[CA_BIT-1:CNT_W];

    xef_ovf_eval u_ovf (
        .op_valid (op_valid),
        .op_class (cls),
        .ovf_en   (ovf_en),
        .carry32  (carry32),
        .carry33  (carry33),
        .md_fits  (md_fits),
        .ov_touch (ov_touch),
        .ov_val   (ov_val)
    );

    xef_ca_eval u_ca (
        .op_valid (op_valid),
        .op_class (cls),
        .carry32  (carry32),
        .sra_lost (sra_lost),
        .ca_touch (ca_touch),
        .ca_val   (ca_val)
    );

    xef_next #(.CNT_W(CNT_W)) u_next (
        .cur_flags (flags_q),
        .cur_cnt   (cnt_q),
        .wr_en     (wr_en),
        .wr_flags  (wr_flags),
        .wr_cnt    (wr_data[CNT_W-1:0]),
        .copy_req  (copy_req),
        .ov_touch  (ov_touch),
        .ov_val    (ov_val),
        .ca_touch  (ca_touch),
        .ca_val    (ca_val),
        .nxt_flags (flags_d),
        .nxt_cnt   (cnt_d),
        .so_final  (so_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            cnt_q   <= '0;
        end else begin
            flags_q <= flags_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        xer_q              = '0;
        xer_q[SO_BIT]      = flags_q.so;
        xer_q[OV_BIT]      = flags_q.ov;
        xer_q[CA_BIT]      = flags_q.ca;
        xer_q[CNT_W-1:0]   = cnt_q;
        copy_nib           = {flags_q.so, flags_q.ov, flags_q.ca, 1'b0};
    end
endmodule

// File: rtl/xef_unit_chk.sv
module xef_unit_chk #(
    parameter int XW    = 32,
    parameter int CNT_W = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_class,
    input logic          ovf_en,
    input logic          sra_lost,
    input logic          wr_en,
    input logic [XW-1:0] wr_data,
    input logic          copy_req,
    input logic [XW-1:0] xer_q,
    input logic          so_now
);
    localparam int SO_BIT = XW - 1;
    localparam int OV_BIT = XW - 2;
    localparam int CA_BIT = XW - 3;

    logic quiet_ops;
    assign quiet_ops = !wr_en && !copy_req;

    a_r6_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_ops && op_valid && op_class == 3'd1) |=> $stable(xer_q));

    a_r7_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_ops && xer_q[SO_BIT]) |=> xer_q[SO_BIT]);

    a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (xer_q[SO_BIT:CA_BIT] == $past(wr_data[SO_BIT:CA_BIT])
                   && xer_q[CNT_W-1:0] == $past(wr_data[CNT_W-1:0])));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xer_q[CA_BIT-1:CNT_W] == '0);

    a_r9_copy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && !wr_en) |=> (xer_q[SO_BIT:CA_BIT] == 3'b000
                                  && $stable(xer_q[CNT_W-1:0])));

    a_r5_sraw_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_ops && op_valid && op_class == 3'd5)
        |=> (xer_q[CA_BIT] == $past(sra_lost) && $stable(xer_q[SO_BIT:OV_BIT])));

    a_r11_so_now: assert property (@(posedge clk) disable iff (!rst_n)
        (so_now && !xer_q[SO_BIT]) |-> (op_valid && ovf_en));
endmodule

bind xef_unit xef_unit_chk #(.XW(XW), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_class (op_class),
    .ovf_en   (ovf_en),
    .sra_lost (sra_lost),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .copy_req (copy_req),
    .xer_q    (xer_q),
    .so_now   (so_now)
);

// File: tb/xef_unit_bench.sv
`timescale 1ns/1ps
module xef_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic        ovf_en = 1'b0, carry32 = 1'b0, carry33 = 1'b0;
    logic        md_fits = 1'b1, sra_lost = 1'b0;
    logic        wr_en = 1'b0, copy_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] xer_q;
    logic        so_now;
    logic [3:0]  copy_nib;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        m_so = 0, m_ov = 0, m_ca = 0;
    logic [6:0]  m_cnt = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    xef_unit u_xef_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .ovf_en(ovf_en), .carry32(carry32), .carry33(carry33), .md_fits(md_fits),
        .sra_lost(sra_lost), .wr_en(wr_en), .wr_data(wr_data), .copy_req(copy_req),
        .xer_q(xer_q), .so_now(so_now), .copy_nib(copy_nib)
    );

    function automatic logic [31:0] model_word();
        return {m_so, m_ov, m_ca, 22'd0, m_cnt};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares the registered word one edge after each drive
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), xer_q, exp_q.pop_front());
        end
    end

    task automatic step(string tag, bit w, logic [31:0] wd, bit cp, bit v,
                        logic [2:0] cls, bit oe, bit c32, bit c33, bit fits, bit lost);
        logic ovt, ovv, cat, cav, so_exp;
        @(negedge clk);
        wr_en = w; wr_data = wd; copy_req = cp; op_valid = v; op_class = cls;
        ovf_en = oe; carry32 = c32; carry33 = c33; md_fits = fits; sra_lost = lost;
        ovt = v && oe && (cls == 3'd2 || cls == 3'd3 || cls == 3'd4);
        ovv = (cls == 3'd4) ? !fits : (c32 ^ c33);
        cat = v && (cls == 3'd3 || cls == 3'd5);
        cav = (cls == 3'd5) ? lost : c32;
        so_exp = m_so | (ovt & ovv);
        #1;
        check({tag, " R11 so_now"}, {31'd0, so_now}, {31'd0, so_exp});
        if (cp) check({tag, " R9 nibble"}, {28'd0, copy_nib}, {28'd0, m_so, m_ov, m_ca, 1'b0});
        if (w) begin
            m_so = wd[31]; m_ov = wd[30]; m_ca = wd[29]; m_cnt = wd[6:0];
        end else if (cp) begin
            m_so = 0; m_ov = 0; m_ca = 0;
        end else begin
            if (ovt) begin m_ov = ovv; m_so = so_exp; end
            if (cat) m_ca = cav;
        end
        @(posedge clk);
        exp_q.push_back(model_word());
        tag_q.push_back(tag);
    endtask

    initial begin
        #(8 * 5000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", xer_q, 32'h0);
        step("R8 write all ones",    1, 32'hFFFF_FFFF, 0, 0, 3'd0, 0, 0, 0, 1, 0);
        step("R9 copy",              0, 32'h0, 1, 0, 3'd0, 0, 0, 0, 1, 0);
        step("R8 so0 ov1",           1, 32'h4000_0005, 0, 0, 3'd0, 0, 0, 0, 1, 0);
        step("R2 add ovf",           0, 32'h0, 0, 1, 3'd2, 1, 1, 0, 1, 0);
        step("R7 add no ovf",        0, 32'h0, 0, 1, 3'd2, 1, 1, 1, 1, 0);
        step("R6 add oe off",        0, 32'h0, 0, 1, 3'd2, 0, 1, 0, 1, 0);
        step("R6 compare",           0, 32'h0, 0, 1, 3'd1, 1, 1, 0, 0, 1);
        step("R3 addc carry",        0, 32'h0, 0, 1, 3'd3, 0, 1, 0, 1, 0);
        step("R5 sraw clear",        0, 32'h0, 0, 1, 3'd5, 1, 1, 0, 0, 0);
        step("R5 sraw set",          0, 32'h0, 0, 1, 3'd5, 0, 0, 0, 1, 1);
        step("R9 copy again",        0, 32'h0, 1, 0, 3'd0, 0, 0, 0, 1, 0);
        step("R4 muldiv ovf",        0, 32'h0, 0, 1, 3'd4, 1, 0, 0, 0, 0);
        step("R4 muldiv fits",       0, 32'h0, 0, 1, 3'd4, 1, 0, 0, 1, 0);
        step("R10 write beats all",  1, 32'h0000_0003, 1, 1, 3'd2, 1, 1, 0, 1, 0);
        step("R3 addc ovf",          0, 32'h0, 0, 1, 3'd3, 1, 1, 0, 1, 0);
        step("R10 copy beats op",    0, 32'h0, 1, 1, 3'd5, 0, 0, 0, 1, 1);
        step("R6 none",              0, 32'h0, 0, 1, 3'd0, 1, 1, 0, 0, 1);
        step("R4 muldiv oe off",     0, 32'h0, 0, 1, 3'd4, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule